// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block watches eight interrupt lines and decides whether the processor should be interrupted, and by which line. It keeps three per-line registers: pending requests, a mask, and the set of lines currently in service. A per-line selection register picks whether each line is captured on its rising edge or follows its level. The priority order is a ring of eight lines. A base register names the line that currently has the highest priority, and priority falls off in ascending line order from there, wrapping past line 7 back to line 0.

The processor side drives plain strobes. An acknowledge strobe moves the winning line into service. End-of-interrupt commands retire a line in service: either the highest-priority one, or a line named by number, each with an optional rotation of the ring. A set-base strobe programs the ring directly, and a configuration strobe loads four mode bits: auto end-of-interrupt, rotate on auto end-of-interrupt, fully nested exclusion of the cascade line, and masked-service exclusion. The outputs are the request flag and the 3-bit winning line, together with the request, in-service and base registers for observation.

The block holds no sequencing state machine. Each strobe is a single-cycle transition that is applied at the next clock edge. The request flag and the winning line follow combinationally from the registers.

Top module: `prio_irq_resolver`

## Requirements
- R1: A line whose bit in the trigger-select register is 1 is level captured. Its request bit equals the input level sampled at the previous clock edge, and an acknowledge does not clear it.
- R2: A line whose trigger-select bit is 0 is edge captured. It sets its request bit only when the input is high and was low at the previous edge. A line held high after its request has been cleared does not set the bit again until the input has gone low and then high.
- R3: Only request bits whose mask bit is 0 can win. A mask write takes effect on the next cycle.
- R4: The winning line is the first pending unmasked line found when stepping upward from the base, modulo 8. A set-base strobe naming line L makes the base (L+1) mod 8.
- R5: The request flag is high only when the pending winner has strictly higher priority than the highest-priority line in service. A pending line at or below the service level does not raise the flag.
- R6: An acknowledge while the flag is high sets the winner's in-service bit, clears its request bit if the line is edge captured, and lowers the flag unless a higher line is pending.
- R7: With auto end-of-interrupt enabled, an acknowledge leaves the in-service register unchanged. If rotate-on-auto-EOI is also enabled, the base becomes (winner+1) mod 8.
- R8: End-of-interrupt code 2'b10 clears the in-service bit of the named line. Code 2'b11 does the same and also sets the base to (named line+1) mod 8.
- R9: End-of-interrupt code 2'b00 clears the highest-priority in-service bit. Code 2'b01 does the same and also sets the base to (cleared line+1) mod 8.
- R10: With fully nested mode set on a master instance, in-service bit 2 is left out of the service-level search. A new request on line 2 can then interrupt while line 2 is in service.
- R11: With special mask mode set, in-service bits whose mask bit is 1 are left out of the service-level search.
- R12: Reset clears the request, in-service and mask registers, the base and all four mode bits. The trigger-select register keeps its value.
- R13: An acknowledge while the request flag is low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt input lines, bit i is line i |
| trig_wr | input | 1 | Load the trigger-select register |
| trig_data | input | 8 | Trigger select, 1 = level, 0 = edge |
| mask_wr | input | 1 | Load the mask register |
| mask_data | input | 8 | Mask value, 1 = line masked |
| cfg_wr | input | 1 | Load the four mode bits |
| cfg_auto_eoi | input | 1 | Auto end-of-interrupt mode |
| cfg_rot_aeoi | input | 1 | Rotate on auto end-of-interrupt |
| cfg_nested | input | 1 | Fully nested exclusion of line 2 |
| cfg_smask | input | 1 | Special mask mode |
| base_wr | input | 1 | Set-base strobe |
| base_line | input | 3 | Line that becomes lowest priority |
| ack | input | 1 | Acknowledge strobe |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| eoi_cmd | input | 2 | End-of-interrupt kind (see R8, R9) |
| eoi_line | input | 3 | Line named by a specific end-of-interrupt |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_line | output | 3 | Winning line number |
| irr_o | output | 8 | Request register |
| isr_o | output | 8 | In-service register |
| base_o | output | 3 | Current highest-priority line |

## Verification
Arbitration is driven with several request patterns. Two unmasked pending lines under different base values show that the search really starts from the base, and does not simply pick the lowest line number. Nested patterns, with a lower line in service while higher and lower lines arrive, separate a strict-priority comparison from a non-strict one. Single-cycle pulses and held-high inputs separate edge capture from level capture. End-of-interrupt and acknowledge sequences are each run with and without rotation, and with each mode bit set, so that every change to the base and every exclusion rule shows up on irq_req, irq_line or base_o.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    typedef enum logic [1:0] {
        EOI_HIGHEST     = 2'b00,
        EOI_HIGHEST_ROT = 2'b01,
        EOI_NAMED       = 2'b10,
        EOI_NAMED_ROT   = 2'b11
    } eoi_kind_e;

    typedef struct packed {
        logic auto_eoi;
        logic rot_aeoi;
        logic nested;
        logic smask;
    } mode_t;

endpackage

// File: rtl/irq_prio_search.sv
module irq_prio_search #(
    parameter int NLINES = 8,
    localparam int IDW = $clog2(NLINES)
) (
    input  logic [NLINES-1:0] vec,
    input  logic [IDW-1:0]    base,
    output logic [IDW:0]      prio
);
    logic [IDW-1:0] idx;

    // Relative priority of the first set bit at or after base; NLINES when empty.
    always_comb begin
        prio = (IDW+1)'(NLINES);
        idx  = '0;
        for (int p = NLINES - 1; p >= 0; p--) begin
            idx = base + IDW'(p);
            if (vec[idx]) prio = (IDW+1)'(p);
        end
    end
endmodule

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int NLINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_in,
    input  logic [NLINES-1:0] lvl,
    input  logic [NLINES-1:0] clr,
    output logic [NLINES-1:0] irr
);
    logic [NLINES-1:0] last_q;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                irr[i]    <= 1'b0;
                last_q[i] <= 1'b0;
            end else begin
                last_q[i] <= irq_in[i];
                if (lvl[i]) begin
                    irr[i] <= irq_in[i];
                end else if (irq_in[i] && !last_q[i]) begin
                    irr[i] <= 1'b1;
                end else if (clr[i]) begin
                    irr[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
    import irq_res_pkg::*;
#(
    parameter int NLINES       = 8,
    parameter bit IS_MASTER    = 1'b1,
    parameter int CASCADE_LINE = 2,
    localparam int IDW = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_in,
    input  logic              trig_wr,
    input  logic [NLINES-1:0] trig_data,
    input  logic              mask_wr,
    input  logic [NLINES-1:0] mask_data,
    input  logic              cfg_wr,
    input  logic              cfg_auto_eoi,
    input  logic              cfg_rot_aeoi,
    input  logic              cfg_nested,
    input  logic              cfg_smask,
    input  logic              base_wr,
    input  logic [IDW-1:0]    base_line,
    input  logic              ack,
    input  logic              eoi_wr,
    input  logic [1:0]        eoi_cmd,
    input  logic [IDW-1:0]    eoi_line,
    output logic              irq_req,
    output logic [IDW-1:0]    irq_line,
    output logic [NLINES-1:0] irr_o,
    output logic [NLINES-1:0] isr_o,
    output logic [IDW-1:0]    base_o
);
    localparam logic [NLINES-1:0] CASC_BIT = NLINES'(1) << CASCADE_LINE;

    logic [NLINES-1:0] lvl_q, imr_q, isr_q, isr_n, irr;
    logic [IDW-1:0]    base_q, base_n, eoi_tgt;
    mode_t             mode_q;
    logic [IDW:0]      pend_p, svc_p, eoi_p;
    logic [NLINES-1:0] cand, svc_vec, clr_vec;
    logic              ack_take;

    assign cand    = irr & ~imr_q;
    assign svc_vec = isr_q
                   & ~(mode_q.smask ? imr_q : '0)
                   & ~((IS_MASTER && mode_q.nested) ? CASC_BIT : '0);

    irq_prio_search #(.NLINES(NLINES)) u_pend (.vec(cand),    .base(base_q), .prio(pend_p));
    irq_prio_search #(.NLINES(NLINES)) u_svc  (.vec(svc_vec), .base(base_q), .prio(svc_p));
    irq_prio_search #(.NLINES(NLINES)) u_eoi  (.vec(isr_q),   .base(base_q), .prio(eoi_p));

    assign irq_req  = (pend_p < svc_p);
    assign irq_line = pend_p[IDW-1:0] + base_q;
    assign ack_take = ack && irq_req;
    assign clr_vec  = ack_take ? (NLINES'(1) << irq_line) : '0;
    assign eoi_tgt  = eoi_p[IDW-1:0] + base_q;

    irq_req_capture #(.NLINES(NLINES)) u_cap (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .lvl(lvl_q), .clr(clr_vec), .irr(irr)
    );

    // Next-state: end-of-interrupt first, then set-base, then acknowledge.
    always_comb begin
        isr_n  = isr_q;
        base_n = base_q;
        if (eoi_wr) begin
            unique case (eoi_kind_e'(eoi_cmd))
                EOI_HIGHEST, EOI_HIGHEST_ROT: begin
                    if (!eoi_p[IDW]) begin
                        isr_n[eoi_tgt] = 1'b0;
                        if (eoi_cmd[0]) base_n = eoi_tgt + IDW'(1);
                    end
                end
                EOI_NAMED, EOI_NAMED_ROT: begin
                    isr_n[eoi_line] = 1'b0;
                    if (eoi_cmd[0]) base_n = eoi_line + IDW'(1);
                end
            endcase
        end
        if (base_wr) base_n = base_line + IDW'(1);
        if (ack_take) begin
            if (mode_q.auto_eoi) begin
                if (mode_q.rot_aeoi) base_n = irq_line + IDW'(1);
            end else begin
                isr_n[irq_line] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imr_q  <= '0;
            isr_q  <= '0;
            base_q <= '0;
            mode_q <= '0;
        end else begin
            isr_q  <= isr_n;
            base_q <= base_n;
            if (mask_wr) imr_q <= mask_data;
            if (cfg_wr)  mode_q <= '{auto_eoi: cfg_auto_eoi, rot_aeoi: cfg_rot_aeoi,
                                     nested: cfg_nested, smask: cfg_smask};
        end
    end

    // Trigger selection survives reset.
    always_ff @(posedge clk) begin
        if (trig_wr) lvl_q <= trig_data;
    end

    assign irr_o  = irr;
    assign isr_o  = isr_q;
    assign base_o = base_q;
endmodule

// File: rtl/irq_res_chk.sv
module irq_res_chk #(
    parameter int NLINES = 8,
    localparam int IDW = $clog2(NLINES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NLINES-1:0] irq_in,
    input logic [NLINES-1:0] lvl_q,
    input logic [NLINES-1:0] imr_q,
    input logic              auto_eoi,
    input logic              ack,
    input logic              eoi_wr,
    input logic [1:0]        eoi_cmd,
    input logic [IDW-1:0]    eoi_line,
    input logic              irq_req,
    input logic [IDW-1:0]    irq_line,
    input logic [NLINES-1:0] irr_o,
    input logic [NLINES-1:0] isr_o
);
    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((irr_o ^ $past(irq_in)) & $past(lvl_q)) == '0)); // R1

    AST_WINNER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irr_o[irq_line] && !imr_q[irq_line])); // R3

    AST_ACK_INSERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req && !auto_eoi && !eoi_wr) |=> isr_o[$past(irq_line)]); // R6

    AST_AEOI_NO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && auto_eoi && !eoi_wr) |=> (isr_o == $past(isr_o))); // R7

    AST_NAMED_EOI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && eoi_cmd[1] && !ack) |=> !isr_o[$past(eoi_line)]); // R8

    AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_req && !eoi_wr) |=> $stable(isr_o)); // R13
endmodule

bind prio_irq_resolver irq_res_chk #(.NLINES(NLINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .lvl_q(lvl_q), .imr_q(imr_q),
    .auto_eoi(mode_q.auto_eoi), .ack(ack), .eoi_wr(eoi_wr), .eoi_cmd(eoi_cmd),
    .eoi_line(eoi_line), .irq_req(irq_req), .irq_line(irq_line),
    .irr_o(irr_o), .isr_o(isr_o)
);

// File: tb/sim_prio_irq_resolver.sv
`timescale 1ns/1ps
module sim_prio_irq_resolver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0, trig_data = 8'h80, mask_data = '0;
    logic       trig_wr = 1'b1, mask_wr = 1'b0, cfg_wr = 1'b0;
    logic       cfg_auto_eoi = 1'b0, cfg_rot_aeoi = 1'b0, cfg_nested = 1'b0, cfg_smask = 1'b0;
    logic       base_wr = 1'b0, ack = 1'b0, eoi_wr = 1'b0;
    logic [2:0] base_line = '0, eoi_line = '0;
    logic [1:0] eoi_cmd = '0;
    logic       irq_req;
    logic [2:0] irq_line, base_o;
    logic [7:0] irr_o, isr_o;
    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    prio_irq_resolver u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig_wr(trig_wr), .trig_data(trig_data),
        .mask_wr(mask_wr), .mask_data(mask_data), .cfg_wr(cfg_wr),
        .cfg_auto_eoi(cfg_auto_eoi), .cfg_rot_aeoi(cfg_rot_aeoi), .cfg_nested(cfg_nested),
        .cfg_smask(cfg_smask), .base_wr(base_wr), .base_line(base_line), .ack(ack),
        .eoi_wr(eoi_wr), .eoi_cmd(eoi_cmd), .eoi_line(eoi_line), .irq_req(irq_req),
        .irq_line(irq_line), .irr_o(irr_o), .isr_o(isr_o), .base_o(base_o)
    );

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_in = '0; step(); step(); rst_n = 1'b1; step();
    endtask
    task automatic pulse(input int i);
        irq_in[i] = 1'b1; step(); irq_in[i] = 1'b0; step();
    endtask
    task automatic do_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask
    task automatic do_eoi(input logic [1:0] c, input logic [2:0] l);
        eoi_wr = 1'b1; eoi_cmd = c; eoi_line = l; step(); eoi_wr = 1'b0;
    endtask
    task automatic set_mask(input logic [7:0] m);
        mask_wr = 1'b1; mask_data = m; step(); mask_wr = 1'b0;
    endtask
    task automatic set_cfg(input logic a, input logic r, input logic n, input logic s);
        cfg_wr = 1'b1; cfg_auto_eoi = a; cfg_rot_aeoi = r; cfg_nested = n; cfg_smask = s;
        step(); cfg_wr = 1'b0;
    endtask
    task automatic set_base(input logic [2:0] l);
        base_wr = 1'b1; base_line = l; step(); base_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 irr", irr_o, 0); chk("R12 isr", isr_o, 0);
        chk("R12 base", base_o, 0); chk("R12 req", irq_req, 0);
    endtask

    task automatic t_edge();
        do_reset();
        irq_in[3] = 1'b1; step();
        chk("R2 edge sets", irr_o, 8'h08); chk("R2 line", irq_line, 3); chk("R2 req", irq_req, 1);
        do_ack();
        chk("R6 isr set", isr_o, 8'h08); chk("R6 irr clr", irr_o, 0); chk("R6 req low", irq_req, 0);
        step(); chk("R2 held high no reset", irr_o, 0);
        do_eoi(2'b10, 3'd3); chk("R8 named eoi", isr_o, 0);
        irq_in[3] = 1'b0; step(); irq_in[3] = 1'b1; step();
        chk("R2 re-arm", irr_o, 8'h08);
        irq_in[3] = 1'b0;
    endtask

    task automatic t_level();
        do_reset();
        irq_in[7] = 1'b1; step();
        chk("R1 level set", irr_o, 8'h80); chk("R1 line", irq_line, 7);
        do_ack();
        chk("R1 ack keeps irr", irr_o, 8'h80); chk("R1 isr", isr_o, 8'h80);
        chk("R5 equal prio no req", irq_req, 0);
        irq_in[7] = 1'b0; step(); chk("R1 level drop", irr_o, 0);
        do_eoi(2'b00, 3'd0); chk("R9 highest eoi", isr_o, 0);
    endtask

    task automatic t_mask_rotate();
        do_reset();
        set_mask(8'h02);
        pulse(1); pulse(5);
        chk("R3 irr", irr_o, 8'h22); chk("R3 masked skip", irq_line, 5);
        set_mask(8'h00); chk("R3 unmask", irq_line, 1);
        set_base(3'd1); chk("R4 base", base_o, 2); chk("R4 line", irq_line, 5);
        set_base(3'd5); chk("R4 base wrap", base_o, 6); chk("R4 line wrap", irq_line, 1);
    endtask

    task automatic t_nest();
        do_reset();
        pulse(4); do_ack(); chk("R6 isr4", isr_o, 8'h10);
        pulse(6); chk("R5 lower blocked", irq_req, 0);
        pulse(2); chk("R5 higher wins", irq_req, 1); chk("R5 line2", irq_line, 2);
        do_ack(); chk("R6 nested isr", isr_o, 8'h14);
        do_eoi(2'b00, 3'd0); chk("R9 clears highest", isr_o, 8'h10); chk("R9 still blocked", irq_req, 0);
        do_eoi(2'b01, 3'd0); chk("R9 rot isr", isr_o, 0); chk("R9 rot base", base_o, 5);
        chk("R9 req after", irq_req, 1); chk("R9 line6", irq_line, 6);
    endtask

    task automatic t_aeoi();
        do_reset();
        set_cfg(1, 1, 0, 0);
        pulse(3); do_ack();
        chk("R7 no isr", isr_o, 0); chk("R7 irr clr", irr_o, 0); chk("R7 rot base", base_o, 4);
        set_cfg(1, 0, 0, 0);
        pulse(1); do_ack();
        chk("R7 no isr plain", isr_o, 0); chk("R7 base kept", base_o, 4);
    endtask

    task automatic t_named_rot();
        do_reset();
        pulse(6); do_ack(); chk("R6 isr6", isr_o, 8'h40);
        do_eoi(2'b11, 3'd6); chk("R8 rot isr", isr_o, 0); chk("R8 rot base", base_o, 7);
    endtask

    task automatic t_nested_mode();
        do_reset();
        set_cfg(0, 0, 1, 0);
        pulse(2); do_ack(); chk("R10 isr2", isr_o, 8'h04);
        pulse(2); chk("R10 line2 again", irq_req, 1); chk("R10 line", irq_line, 2);
        do_reset();
        pulse(2); do_ack(); pulse(2); chk("R10 off blocks", irq_req, 0);
    endtask

    task automatic t_smask();
        do_reset();
        set_cfg(0, 0, 0, 1);
        pulse(0); do_ack(); pulse(5);
        chk("R11 blocked", irq_req, 0);
        set_mask(8'h01); chk("R11 excluded", irq_req, 1); chk("R11 line", irq_line, 5);
    endtask

    task automatic t_idle_ack();
        do_reset();
        do_ack();
        chk("R13 isr", isr_o, 0); chk("R13 irr", irr_o, 0); chk("R13 base", base_o, 0);
    endtask

    task automatic t_reset_keeps();
        set_cfg(1, 0, 0, 0); set_mask(8'hFF);
        do_reset();
        pulse(0); chk("R12 mask cleared", irq_req, 1);
        do_ack(); chk("R12 mode cleared", isr_o, 8'h01);
        irq_in[7] = 1'b1; step(); do_eoi(2'b00, 3'd0); do_ack();
        chk("R12 trig kept", irr_o, 8'h80);
        irq_in[7] = 1'b0; step();
    endtask

    initial begin
        step(); trig_wr = 1'b0; rst_n = 1'b1; step();
        t_reset();
        t_edge(); t_level(); t_mask_rotate(); t_nest(); t_aeoi();
        t_named_rot(); t_nested_mode(); t_smask(); t_idle_ack(); t_reset_keeps();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule